// File: doc/BRIEF.md
# Use-Counter Cache Replacement Unit

This block holds a small use counter for every way of every set of a set-associative cache and, when the cache asks to fill a line, names the way to evict. One bank of counters serves four policies: least-recently-used, least-frequently-used, first-in-first-out and random. Each policy applies its own update rule to the same counters. Tag storage, data storage and memory traffic belong to the surrounding cache. This unit only tracks usage and picks victims.

Every cycle the cache presents a set index. It may also raise a hit strobe with the way that hit, and it may raise a fill request. A fill returns a registered victim way together with a one-cycle valid strobe. The result arrives in the cycle after the request. Fill requests may come back to back.

The control is a two-state machine. `ST_IDLE` holds no result. `ST_ISSUE` presents a victim. The transition *fill-accept* (from either state, when `fill_i` is high) goes to `ST_ISSUE`. The transition *drain* (from either state, when `fill_i` is low) goes to `ST_IDLE`.

Top module: `way_victim_picker`

## Requirements
- R1: Reset clears every counter to zero and drives `victim_vld_o` and `victim_o` low. The first fill after reset in any set therefore returns way 0.
- R2: `victim_vld_o` is high in exactly the cycle after each cycle where `fill_i` is high, and low otherwise. `victim_o` carries the chosen way in that cycle.
- R3: The mode input selects the policy: 0 is least-recently-used, 1 is least-frequently-used, 2 is first-in-first-out, 3 is random. In modes 0 to 2, the victim is the way with the smallest counter in the addressed set. On a tie the lowest-numbered way wins.
- R4: In mode 0, a hit promotes the hit way. If its old counter value is below WAYS, every other way of that set whose counter exceeds that old value loses one, and the hit way's counter becomes WAYS. Otherwise nothing changes.
- R5: In modes 0 and 1, a fill clears the victim's counter to zero and changes no other counter. A later hit then promotes or counts the new line.
- R6: In mode 1, a hit adds one to the hit way's counter. The counter saturates at 2^CW-1, where CW is the counter width, and does not wrap to zero.
- R7: In mode 2, hits leave all counters unchanged. A fill clears the victim's counter and then promotes it with the rule of R4, so victims rotate in fill order.
- R8: In mode 3, the victim is the low log2(WAYS) bits of a free-running maximal-length LFSR, so any way can be chosen. Hits and fills leave every counter unchanged.
- R9: When `fill_i` and `hit_i` are high in the same cycle, the fill is carried out and the hit has no effect on any counter.
- R10: Counter updates touch only the set addressed by `set_i`. Counters persist when the mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy select (0 LRU, 1 LFU, 2 FIFO, 3 random) |
| set_i | input | log2(SETS) | Set addressed this cycle |
| hit_i | input | 1 | A lookup hit in the addressed set |
| hit_way_i | input | log2(WAYS) | Way that hit |
| fill_i | input | 1 | Request a victim for the addressed set |
| victim_o | output | log2(WAYS) | Way chosen for eviction |
| victim_vld_o | output | 1 | `victim_o` is valid this cycle |

## Verification
A counter that holds a wrong value is not visible at the ports until a fill selects a victim in that set. The bench therefore follows every stimulus pattern with fills. It compares each returned way against a counter model that the bench keeps, and it compares in the cycle after the request. An error shows up at the first fill in the affected set whose minimum search depends on the corrupted counter. It can stay hidden for several fills if the bad value is not the smallest. For this reason the sweeps fill each set repeatedly, and they force saturation and mode changes so that stale counters are exposed by a later choice.

// File: rtl/way_victim_pkg.sv
package way_victim_pkg;
    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_LFU  = 2'd1,
        POL_FIFO = 2'd2,
        POL_RAND = 2'd3
    } policy_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } pick_state_e;
endpackage

// File: rtl/way_lfsr.sv
module way_lfsr #(
    parameter int LW   = 16,
    parameter int OUTW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [OUTW-1:0] rnd_o
);
    localparam logic [15:0] TAPS = 16'hB400;
    localparam logic [LW-1:0] SEED = LW'(16'hACE1);

    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= (q >> 1) ^ ({LW{q[0]}} & LW'(TAPS));
        end
    end

    assign rnd_o = q[OUTW-1:0];

    // R8: a maximal-length register never reaches the all-zero lock state
    p_lfsr_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/way_min_select.sv
module way_min_select
    import way_victim_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int CW   = 3,
    parameter int WW   = 2
) (
    input  logic [WAYS-1:0][CW-1:0] cnt_i,
    input  policy_e                 mode_i,
    input  logic [WW-1:0]           rnd_i,
    output logic [WW-1:0]           way_o
);
    logic [WW-1:0] best_way;
    logic [CW-1:0] best_val;

    always_comb begin
        best_way = '0;
        best_val = cnt_i[0];
        for (int w = 1; w < WAYS; w++) begin
            if (cnt_i[w] < best_val) begin
                best_val = cnt_i[w];
                best_way = WW'(w);
            end
        end
        way_o = (mode_i == POL_RAND) ? rnd_i : best_way;
    end
endmodule

// File: rtl/way_count_update.sv
module way_count_update
    import way_victim_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int CW   = 3,
    parameter int WW   = 2
) (
    input  logic [WAYS-1:0][CW-1:0] cur_i,
    input  policy_e                 mode_i,
    input  logic                    fill_i,
    input  logic [WW-1:0]           vic_way_i,
    input  logic                    hit_i,
    input  logic [WW-1:0]           hit_way_i,
    output logic [WAYS-1:0][CW-1:0] nxt_o,
    output logic                    we_o
);
    localparam logic [CW-1:0] TOP = CW'(WAYS);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic [CW-1:0] old_val;

    always_comb begin
        nxt_o   = cur_i;
        we_o    = 1'b0;
        old_val = cur_i[hit_way_i];
        if (fill_i) begin
            if (mode_i != POL_RAND) begin
                we_o = 1'b1;
                nxt_o[vic_way_i] = '0;
                if (mode_i == POL_FIFO) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (WW'(w) != vic_way_i && cur_i[w] != '0) begin
                            nxt_o[w] = cur_i[w] - 1'b1;
                        end
                    end
                    nxt_o[vic_way_i] = TOP;
                end
            end
        end else if (hit_i) begin
            unique case (mode_i)
                POL_LRU: begin
                    we_o = 1'b1;
                    if (old_val < TOP) begin
                        for (int w = 0; w < WAYS; w++) begin
                            if (WW'(w) != hit_way_i && cur_i[w] > old_val) begin
                                nxt_o[w] = cur_i[w] - 1'b1;
                            end
                        end
                        nxt_o[hit_way_i] = TOP;
                    end
                end
                POL_LFU: begin
                    we_o = 1'b1;
                    if (old_val != SAT) begin
                        nxt_o[hit_way_i] = old_val + 1'b1;
                    end
                end
                POL_FIFO, POL_RAND: begin
                    we_o = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/way_victim_picker.sv
module way_victim_picker
    import way_victim_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int LFSR_W = 16,
    localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SW = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int CW = $clog2(WAYS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [SW-1:0] set_i,
    input  logic          hit_i,
    input  logic [WW-1:0] hit_way_i,
    input  logic          fill_i,
    output logic [WW-1:0] victim_o,
    output logic          victim_vld_o
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    logic [SETS-1:0][WAYS-1:0][CW-1:0] cnt_q;
    logic [WAYS-1:0][CW-1:0]           cur_set;
    logic [WAYS-1:0][CW-1:0]           nxt_set;
    logic                              cnt_we;
    logic [WW-1:0]                     rnd_way;
    logic [WW-1:0]                     pick_way;
    policy_e                           mode;
    pick_state_e                       state_q;
    pick_state_e                       state_d;

    assign mode    = policy_e'(mode_i);
    assign cur_set = cnt_q[set_i];

    way_lfsr #(.LW(LFSR_W), .OUTW(WW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd_way)
    );

    way_min_select #(.WAYS(WAYS), .CW(CW), .WW(WW)) u_sel (
        .cnt_i  (cur_set),
        .mode_i (mode),
        .rnd_i  (rnd_way),
        .way_o  (pick_way)
    );

    way_count_update #(.WAYS(WAYS), .CW(CW), .WW(WW)) u_upd (
        .cur_i     (cur_set),
        .mode_i    (mode),
        .fill_i    (fill_i),
        .vic_way_i (pick_way),
        .hit_i     (hit_i),
        .hit_way_i (hit_way_i),
        .nxt_o     (nxt_set),
        .we_o      (cnt_we)
    );

    // counter bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q[set_i] <= nxt_set;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = fill_i ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = fill_i ? ST_ISSUE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_o <= '0;
        end else if (fill_i) begin
            victim_o <= pick_way;
        end
    end

    assign victim_vld_o = (state_q == ST_ISSUE);

    p_vld_follows_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> victim_vld_o);
    p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_i |=> !victim_vld_o);
    p_victim_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && (mode == POL_LRU || mode == POL_LFU))
        |=> cnt_q[$past(set_i)][victim_o] == '0);
    p_fifo_hit_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !fill_i && mode == POL_FIFO)
        |=> cnt_q[$past(set_i)] == $past(cnt_q[set_i]));
    p_rand_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == POL_RAND) |=> cnt_q == $past(cnt_q));
    p_lfu_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !fill_i && mode == POL_LFU && cur_set[hit_way_i] == SAT)
        |=> cnt_q[$past(set_i)][$past(hit_way_i)] == SAT);
endmodule

// File: tb/way_victim_picker_tb_top.sv
module way_victim_picker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 4;
    localparam int SETS = 8;
    localparam int WW   = 2;
    localparam int SW   = 3;
    localparam int TOP  = 4;
    localparam int SAT  = 7;
    localparam logic [1:0] M_LRU = 2'd0, M_LFU = 2'd1, M_FIFO = 2'd2, M_RAND = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [SW-1:0] set_i = '0;
    logic          hit_i = 1'b0;
    logic [WW-1:0] hit_way_i = '0;
    logic          fill_i = 1'b0;
    logic [WW-1:0] victim_o;
    logic          victim_vld_o;

    int total = 0;
    int bad = 0;
    int mdl [SETS][WAYS];
    int unsigned lcg = 32'h1234_5678;
    bit seen [WAYS];

    way_victim_picker #(.WAYS(WAYS), .SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .set_i(set_i),
        .hit_i(hit_i), .hit_way_i(hit_way_i), .fill_i(fill_i),
        .victim_o(victim_o), .victim_vld_o(victim_vld_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int n);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) % n);
    endfunction

    function automatic int model_min(input int s);
        int b = 0;
        for (int w = 1; w < WAYS; w++) if (mdl[s][w] < mdl[s][b]) b = w;
        return b;
    endfunction

    function automatic void model_promote(input int s, input int w);
        int old = mdl[s][w];
        if (old < TOP) begin
            for (int o = 0; o < WAYS; o++) if (o != w && mdl[s][o] > old) mdl[s][o]--;
            mdl[s][w] = TOP;
        end
    endfunction

    // one cycle of stimulus; called at a falling edge, returns at the next one
    task automatic op(input logic [1:0] m, input int s, input bit f, input bit h,
                      input int hw, input bit chk_way, output int got);
        int exp_way = 0;
        mode_i = m; set_i = SW'(s); fill_i = f; hit_i = h; hit_way_i = WW'(hw);
        if (f && m != M_RAND) begin
            exp_way = model_min(s);
            mdl[s][exp_way] = 0;                       // R5, R7
            if (m == M_FIFO) model_promote(s, exp_way);
        end else if (!f && h) begin                    // R9: fill wins
            if (m == M_LRU) model_promote(s, hw);      // R4
            else if (m == M_LFU && mdl[s][hw] < SAT) mdl[s][hw]++; // R6
        end
        @(negedge clk);
        got = int'(victim_o);
        check("R2 valid strobe", int'(victim_vld_o), int'(f));
        if (f && chk_way) check("R3 victim way", got, exp_way);
        fill_i = 1'b0; hit_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fill_i = 1'b0; hit_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mdl[s][w] = 0;
    endtask

    initial begin
        int got;
        do_reset();
        // R1: reset state
        check("R1 valid after reset", int'(victim_vld_o), 0);
        check("R1 victim after reset", int'(victim_o), 0);
        for (int s = 0; s < SETS; s++) begin
            op(M_LRU, s, 1, 0, 0, 0, got);
            check("R1 first fill way 0", got, 0);
        end

        // sweeps per counted policy, with mixed hits, fills and collisions
        for (int mi = 0; mi < 3; mi++) begin
            do_reset();
            for (int i = 0; i < 400; i++) begin
                int k = rnd(8);
                op(2'(mi), rnd(SETS), k < 3, k >= 2 && k < 7, rnd(WAYS), 1, got);
            end
        end

        // R6: saturation under LFU in set 5
        do_reset();
        for (int w = 0; w < WAYS; w++) op(M_LFU, 5, 0, 1, w, 1, got);
        for (int i = 0; i < 7; i++) op(M_LFU, 5, 0, 1, 2, 1, got);
        op(M_LFU, 5, 1, 0, 0, 1, got);
        check("R6 saturated way kept", got, 0);

        // R7: FIFO rotation ignores hits
        do_reset();
        for (int i = 0; i < 8; i++) begin
            op(M_FIFO, 3, 0, 1, 0, 1, got);
            op(M_FIFO, 3, 1, 0, 0, 1, got);
            check("R7 rotation order", got, i % WAYS);
        end

        // R8/R10: random policy leaves counters alone, covers every way
        do_reset();
        op(M_LRU, 1, 0, 1, 3, 1, got);
        op(M_LRU, 1, 0, 1, 0, 1, got);
        op(M_LRU, 1, 0, 1, 1, 1, got);
        for (int w = 0; w < WAYS; w++) seen[w] = 0;
        for (int i = 0; i < 80; i++) begin
            op(M_RAND, 1, i % 2 == 0, 1, rnd(WAYS), 0, got);
            if (i % 2 == 0) seen[got] = 1;
        end
        for (int w = 0; w < WAYS; w++) check("R8 way reachable", int'(seen[w]), 1);
        op(M_LRU, 1, 1, 0, 0, 1, got);
        check("R8 counters untouched", got, 2);
        op(M_LRU, 1, 1, 0, 0, 1, got);
        check("R10 mode switch persists", got, 2);
        op(M_LRU, 6, 1, 0, 0, 1, got);
        check("R10 other set untouched", got, 0);

        // R2: idle cycle shows no strobe
        op(M_LRU, 0, 0, 0, 0, 1, got);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule